// File: doc/BRIEF.md
# Chained Board Record Forwarder

This block sits on each board of a vertical stack of readout boards and merges two record streams into one. Local hits arrive as a byte stream of pairs: a channel byte, then a time byte. Records from the board below arrive on the upstream port as complete three-byte records. A byte-wide forwarding queue buffers the upstream records. An arbiter interleaves whole records from both sources and sends the merged stream toward the top of the stack.

Each local pair is sent as a three-beat record. The first beat carries this board's 4-bit address in its low nibble, and the channel and time bytes follow. Forwarded records leave exactly as they arrived, so the address of their origin board survives every hop. Two static straps set the board's position. A bottom board refuses all upstream traffic. A top board sends the merged stream to the host serial link instead of the downstream port.

Top module: `chain_rec_forwarder`

## Requirements
- R1: After reset, with neither strap set, `dn_valid` and `host_valid` are 0, and `up_ready` and `loc_ready` are 1.
- R2: Local bytes are paired in arrival order, first the channel byte and then the time byte. Each pair is emitted as three beats: `{4'b0000, brd_addr}`, then the channel byte, then the time byte.
- R3: Each three-byte record accepted on the upstream port is emitted byte for byte unchanged. Forwarded records leave in the order they arrived.
- R4: Once the first beat of a record is emitted, the next two bytes accepted on the output belong to that same record.
- R5: A record boundary with both a complete forwarded record and a complete local record waiting is a tie. On a tie, the chosen source is the opposite of the source chosen last. The first tie after reset goes to the local record.
- R6: `up_ready` is 0 whenever the forwarding queue holds at least `FIFO_DEPTH - NEAR_SLACK` bytes (13 with the defaults). No accepted byte is ever lost.
- R7: With `strap_bottom` = 1, `up_ready` stays 0 and `up_valid`/`up_byte` have no effect on the output.
- R8: With `strap_top` = 1, records leave on the host port and `dn_valid` stays 0. With `strap_top` = 0, records leave on the downstream port and `host_valid` stays 0.
- R9: While the selected output port shows valid with its ready low, the valid and the byte on that port hold unchanged.
- R10: `loc_ready` is 0 while a complete local record is held. This lasts from the cycle after its time byte is taken until its last beat is accepted on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| brd_addr | input | 4 | Static address of this board |
| strap_top | input | 1 | Static: this board is the top of the stack |
| strap_bottom | input | 1 | Static: this board is the bottom of the stack |
| loc_valid | input | 1 | Local byte present |
| loc_byte | input | 8 | Local byte (channel, then time) |
| loc_ready | output | 1 | Local byte accepted this cycle if valid |
| up_valid | input | 1 | Upstream byte present |
| up_byte | input | 8 | Upstream record byte |
| up_ready | output | 1 | Forwarding queue accepts a byte |
| dn_valid | output | 1 | Downstream beat present |
| dn_byte | output | 8 | Downstream beat |
| dn_ready | input | 1 | Downstream port takes the beat |
| host_valid | output | 1 | Host link beat present |
| host_byte | output | 8 | Host link beat |
| host_ready | input | 1 | Host link takes the beat |

## Verification
A queued forwarded record, or a local record whose time byte was taken at some edge, is granted at the next edge. Its first beat can therefore transfer one edge later, and the following beats go out on consecutive accepted cycles. A change in queue occupancy shows on `up_ready` right after the edge that caused it. The bench drives inputs just after the falling edge. It samples ports one nanosecond later, so every observed transfer belongs to the following rising edge. Records are compared as whole three-beat units against per-source expected queues, which checks ordering and contiguity wherever a beat lands. The tie-break and fill-level cases are forced by holding the output ready low for a fixed number of cycles before releasing it.

// File: rtl/crf_pkg.sv
// Package: shared constants and types for the chained record forwarder.
// Assumes records are always three bytes long on every port.
package crf_pkg;
    localparam int REC_BEATS = 3;
    localparam int BEAT_W    = 2;

    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_FWD   = 1'b1
    } src_e;

    // Address nibble zero-extended into the leading beat of a local record.
    function automatic logic [7:0] lead_beat(input logic [3:0] addr);
        return {4'b0000, addr};
    endfunction
endpackage

// File: rtl/crf_fwd_fifo.sv
// Module: byte queue holding records received from the board below.
// Drops ready once occupancy reaches DEPTH - SLACK; a blocked input holds
// ready low permanently. Assumes DEPTH is a power of two and that pops are
// issued only when bytes are present.
module crf_fwd_fifo #(
    parameter int DEPTH = 16,
    parameter int SLACK = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_in,
    input  logic          wr_valid,
    input  logic [7:0]    wr_byte,
    output logic          wr_ready,
    input  logic          rd_pop,
    output logic [7:0]    rd_byte,
    output logic          has_record,
    output logic [CW-1:0] fill
);
    localparam int FILL_LIMIT = DEPTH - SLACK;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_fire;

    assign wr_ready   = !block_in && (fill < CW'(FILL_LIMIT));
    assign wr_fire    = wr_valid && wr_ready;
    assign rd_byte    = mem[rd_ptr];
    assign has_record = fill >= CW'(crf_pkg::REC_BEATS);

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
            if (rd_pop)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + CW'(wr_fire) - CW'(rd_pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_ptr] <= wr_byte;
    end
endmodule

// File: rtl/crf_local_stage.sv
// Module: pairs the local byte stream into one held record (channel, time).
// Holds the pair until the arbiter releases it; accepts nothing while full.
module crf_local_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loc_valid,
    input  logic [7:0] loc_byte,
    output logic       loc_ready,
    input  logic       release_rec,
    output logic       full,
    output logic [7:0] chan,
    output logic [7:0] tstamp
);
    logic [1:0] cnt_q;

    assign full      = cnt_q == 2'd2;
    assign loc_ready = !full;

    // Capture channel then time; clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            chan   <= '0;
            tstamp <= '0;
        end else if (release_rec) begin
            cnt_q <= '0;
        end else if (loc_valid && loc_ready) begin
            if (cnt_q == 2'd0) chan   <= loc_byte;
            else               tstamp <= loc_byte;
            cnt_q <= cnt_q + 2'd1;
        end
    end
endmodule

// File: rtl/crf_arbiter.sv
// Module: picks whole records from the forwarding queue or the local stage
// and emits them beat by beat. Alternates sources on a tie; the first tie
// after reset goes to local. Assumes a granted forwarded record is fully
// present in the queue (grant requires three queued bytes).
module crf_arbiter
    import crf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        brd_addr,
    input  logic              fwd_has_rec,
    input  logic [7:0]        fwd_byte,
    output logic              fwd_pop,
    input  logic              loc_full,
    input  logic [7:0]        loc_chan,
    input  logic [7:0]        loc_tstamp,
    output logic              loc_release,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output src_e              src,
    output src_e              last_src
);
    logic fire, last_beat;
    src_e pick;

    assign fire      = busy && out_ready;
    assign last_beat = beat == BEAT_W'(REC_BEATS - 1);
    assign out_valid = busy;
    assign fwd_pop   = fire && (src == SRC_FWD);
    assign loc_release = fire && (src == SRC_LOCAL) && last_beat;

    // Source choice at a record boundary.
    always_comb begin
        if (fwd_has_rec && loc_full)
            pick = (last_src == SRC_FWD) ? SRC_LOCAL : SRC_FWD;
        else if (fwd_has_rec)
            pick = SRC_FWD;
        else
            pick = SRC_LOCAL;
    end

    // Grant and beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            beat     <= '0;
            src      <= SRC_LOCAL;
            last_src <= SRC_FWD;
        end else if (!busy) begin
            if (fwd_has_rec || loc_full) begin
                busy     <= 1'b1;
                beat     <= '0;
                src      <= pick;
                last_src <= pick;
            end
        end else if (fire) begin
            if (last_beat) busy <= 1'b0;
            else           beat <= beat + 1'b1;
        end
    end

    // Beat contents: forwarded bytes pass through, local ones get the address.
    always_comb begin
        if (src == SRC_FWD)  out_byte = fwd_byte;
        else if (beat == '0) out_byte = lead_beat(brd_addr);
        else if (beat == 2'd1) out_byte = loc_chan;
        else                 out_byte = loc_tstamp;
    end
endmodule

// File: rtl/chain_rec_forwarder.sv
// Module: top of the chained record forwarder. Merges local hit pairs and
// records from the board below into one stream sent upward, either on the
// downstream port or, on the top board, on the host link. Straps are
// static and only change while reset is held.
module chain_rec_forwarder #(
    parameter int FIFO_DEPTH = 16,
    parameter int NEAR_SLACK = 3,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] brd_addr,
    input  logic       strap_top,
    input  logic       strap_bottom,
    input  logic       loc_valid,
    input  logic [7:0] loc_byte,
    output logic       loc_ready,
    input  logic       up_valid,
    input  logic [7:0] up_byte,
    output logic       up_ready,
    output logic       dn_valid,
    output logic [7:0] dn_byte,
    input  logic       dn_ready,
    output logic       host_valid,
    output logic [7:0] host_byte,
    input  logic       host_ready
);
    import crf_pkg::*;

    logic [CW-1:0]     fifo_fill;
    logic              fwd_has_rec, fwd_pop, loc_full, loc_release;
    logic [7:0]        fwd_byte, loc_chan, loc_tstamp, arb_byte;
    logic              arb_valid, arb_ready, arb_busy;
    logic [BEAT_W-1:0] arb_beat;
    src_e              arb_src, arb_last;

    crf_fwd_fifo #(.DEPTH(FIFO_DEPTH), .SLACK(NEAR_SLACK)) u_fifo (
        .clk(clk), .rst_n(rst_n), .block_in(strap_bottom),
        .wr_valid(up_valid), .wr_byte(up_byte), .wr_ready(up_ready),
        .rd_pop(fwd_pop), .rd_byte(fwd_byte),
        .has_record(fwd_has_rec), .fill(fifo_fill)
    );

    crf_local_stage u_local (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_byte(loc_byte), .loc_ready(loc_ready),
        .release_rec(loc_release), .full(loc_full),
        .chan(loc_chan), .tstamp(loc_tstamp)
    );

    crf_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .brd_addr(brd_addr),
        .fwd_has_rec(fwd_has_rec), .fwd_byte(fwd_byte), .fwd_pop(fwd_pop),
        .loc_full(loc_full), .loc_chan(loc_chan), .loc_tstamp(loc_tstamp),
        .loc_release(loc_release),
        .out_valid(arb_valid), .out_byte(arb_byte), .out_ready(arb_ready),
        .busy(arb_busy), .beat(arb_beat), .src(arb_src), .last_src(arb_last)
    );

    // Port steering by the position strap.
    assign arb_ready  = strap_top ? host_ready : dn_ready;
    assign dn_valid   = arb_valid && !strap_top;
    assign host_valid = arb_valid && strap_top;
    assign dn_byte    = strap_top ? 8'h00 : arb_byte;
    assign host_byte  = strap_top ? arb_byte : 8'h00;
endmodule

// File: rtl/crf_checker.sv
// Checker: temporal properties of the chained record forwarder, bound to
// every instance of the top module.
module crf_checker #(
    parameter int FIFO_DEPTH = 16,
    parameter int NEAR_SLACK = 3,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strap_top,
    input logic          strap_bottom,
    input logic          up_ready,
    input logic          dn_valid,
    input logic [7:0]    dn_byte,
    input logic          dn_ready,
    input logic          host_valid,
    input logic [7:0]    host_byte,
    input logic          host_ready,
    input logic [CW-1:0] fifo_fill,
    input logic          fwd_has_rec,
    input logic          loc_full,
    input logic          arb_busy,
    input logic [1:0]    arb_beat,
    input logic          arb_src,
    input logic          arb_last
);
    logic       ov, ordy;
    logic [7:0] ob;
    assign ov   = strap_top ? host_valid : dn_valid;
    assign ob   = strap_top ? host_byte  : dn_byte;
    assign ordy = strap_top ? host_ready : dn_ready;

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_fill <= CW'(FIFO_DEPTH));

    a_r6_ready_low_when_near_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_fill >= CW'(FIFO_DEPTH - NEAR_SLACK)) |-> !up_ready);

    a_r7_bottom_blocks_upstream: assert property (@(posedge clk) disable iff (!rst_n)
        strap_bottom |-> !up_ready);

    a_r8_top_keeps_dn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        strap_top |-> !dn_valid);

    a_r8_chain_keeps_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_top |-> !host_valid);

    a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (ov && !ordy) |=> (ov && $stable(ob)));

    a_r4_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (ov && ordy && arb_beat != 2'd2) |=> ov);

    a_r5_alternate_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_busy && fwd_has_rec && loc_full) |=> (arb_busy && arb_src != $past(arb_last)));
endmodule

bind chain_rec_forwarder crf_checker #(
    .FIFO_DEPTH(FIFO_DEPTH), .NEAR_SLACK(NEAR_SLACK), .CW(CW)
) i_crf_checker (
    .clk(clk), .rst_n(rst_n), .strap_top(strap_top), .strap_bottom(strap_bottom),
    .up_ready(up_ready), .dn_valid(dn_valid), .dn_byte(dn_byte), .dn_ready(dn_ready),
    .host_valid(host_valid), .host_byte(host_byte), .host_ready(host_ready),
    .fifo_fill(fifo_fill), .fwd_has_rec(fwd_has_rec), .loc_full(loc_full),
    .arb_busy(arb_busy), .arb_beat(arb_beat), .arb_src(arb_src), .arb_last(arb_last)
);

// File: tb/test_chain_rec_forwarder.sv
`timescale 1ns/100ps
module test_chain_rec_forwarder;
    localparam int DEPTH = 16;
    localparam int SLACK = 3;
    localparam int LIMIT = DEPTH - SLACK;
    localparam logic [3:0] BRD = 4'h5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, strap_top = 1'b0, strap_bottom = 1'b0;
    logic       loc_valid = 1'b0, up_valid = 1'b0;
    logic [7:0] loc_byte = '0, up_byte = '0;
    logic       loc_ready, up_ready, dn_valid, host_valid;
    logic [7:0] dn_byte, host_byte;
    logic       dn_ready = 1'b0, host_ready = 1'b0;

    chain_rec_forwarder #(.FIFO_DEPTH(DEPTH), .NEAR_SLACK(SLACK)) i_chain_rec_forwarder (
        .clk(clk), .rst_n(rst_n), .brd_addr(BRD),
        .strap_top(strap_top), .strap_bottom(strap_bottom),
        .loc_valid(loc_valid), .loc_byte(loc_byte), .loc_ready(loc_ready),
        .up_valid(up_valid), .up_byte(up_byte), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_byte(dn_byte), .dn_ready(dn_ready),
        .host_valid(host_valid), .host_byte(host_byte), .host_ready(host_ready)
    );

    int total = 0, bad = 0, cyc = 0, up_accepted = 0;
    bit finished = 0, rand_rdy = 0, wrong_port = 0;
    logic [23:0] fwd_q[$];
    logic [15:0] loc_q[$];
    bit          src_log[$];   // 1 = forwarded, 0 = local

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] other_addr(input logic [3:0] a);
        return (a == BRD) ? BRD + 4'd1 : a;
    endfunction

    // Ready randomizer for the random phases.
    always @(negedge clk) begin
        if (rand_rdy) begin
            dn_ready   = ($urandom % 4) != 0;
            host_ready = ($urandom % 4) != 0;
        end
    end

    // Output monitor: sampled 1 ns after the falling edge; a transfer seen
    // here happens at the following rising edge. Parsing whole records
    // relies on R4 contiguity.
    logic [7:0] rb[3];
    int         ri = 0;
    bit         prev_stall = 0;
    logic [7:0] prev_byte;
    always @(negedge clk) begin
        logic ov, ordy;
        logic [7:0] ob;
        logic [23:0] ef;
        logic [15:0] el;
        #1;
        if (rst_n) begin
            ov   = strap_top ? host_valid : dn_valid;
            ob   = strap_top ? host_byte  : dn_byte;
            ordy = strap_top ? host_ready : dn_ready;
            if (strap_top ? dn_valid : host_valid) wrong_port = 1;
            if (prev_stall)
                chk(ov && ob == prev_byte, "R9", "stalled beat held",
                    {23'd0, ov, ob}, {24'd1, prev_byte});
            prev_stall = ov && !ordy;
            prev_byte  = ob;
            if (ov && ordy) begin
                rb[ri] = ob;
                ri++;
                if (ri == 3) begin
                    ri = 0;
                    if (rb[0] == {4'h0, BRD}) begin
                        src_log.push_back(1'b0);
                        el = (loc_q.size() > 0) ? loc_q.pop_front() : 16'hxxxx;
                        chk({rb[1], rb[2]} === el, "R2", "local record",
                            {16'd0, rb[1], rb[2]}, {16'd0, el});
                    end else begin
                        src_log.push_back(1'b1);
                        ef = (fwd_q.size() > 0) ? fwd_q.pop_front() : 24'hxxxxxx;
                        chk({rb[0], rb[1], rb[2]} === ef, "R3", "forwarded record",
                            {8'd0, rb[0], rb[1], rb[2]}, {8'd0, ef});
                    end
                end
            end
        end else begin
            ri = 0;
            prev_stall = 0;
        end
    end

    task automatic send_up(input logic [3:0] a, input logic [7:0] ch, input logic [7:0] tm);
        logic [7:0] b[3];
        b[0] = {4'h0, a}; b[1] = ch; b[2] = tm;
        fwd_q.push_back({b[0], b[1], b[2]});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); up_valid = 1; up_byte = b[i]; #0.5;
            while (!up_ready) begin @(negedge clk); #0.5; end
            up_accepted++;
        end
        @(negedge clk); up_valid = 0;
    endtask

    task automatic send_loc(input logic [7:0] ch, input logic [7:0] tm);
        logic [7:0] b[2];
        b[0] = ch; b[1] = tm;
        loc_q.push_back({ch, tm});
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); loc_valid = 1; loc_byte = b[i]; #0.5;
            while (!loc_ready) begin @(negedge clk); #0.5; end
        end
        @(negedge clk); loc_valid = 0;
    endtask

    task automatic do_reset(input bit top, input bit bottom);
        @(negedge clk);
        rst_n = 0; strap_top = top; strap_bottom = bottom;
        up_valid = 0; loc_valid = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_drain(input string req);
        for (int i = 0; i < 3000 && (fwd_q.size() != 0 || loc_q.size() != 0); i++)
            @(negedge clk);
        repeat (4) @(negedge clk);
        chk(fwd_q.size() == 0 && loc_q.size() == 0, req, "all records delivered",
            fwd_q.size() + loc_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int start;
        int nfwd;
        void'($urandom(32'd1234));

        // R1: reset state
        do_reset(0, 0);
        @(negedge clk); #1;
        chk(!dn_valid && !host_valid, "R1", "no output after reset", {dn_valid, host_valid}, 0);
        chk(up_ready && loc_ready, "R1", "inputs ready after reset", {up_ready, loc_ready}, 2'b11);

        // R2 / R10: one local record held against a stalled output
        dn_ready = 0;
        send_loc(8'h12, 8'h34);
        repeat (2) @(negedge clk); #1;
        chk(!loc_ready, "R10", "loc_ready low while record held", loc_ready, 0);
        chk(dn_valid && dn_byte == {4'h0, BRD}, "R2", "leading beat carries address",
            {dn_valid, dn_byte}, {1'b1, 4'h0, BRD});
        dn_ready = 1;
        wait_drain("R2");

        // R5: tie-break alternation
        dn_ready = 0;
        start = src_log.size();
        fork
            begin
                send_up(4'h1, 8'hA1, 8'hB1);
                send_up(4'h2, 8'hA2, 8'hB2);
                send_up(4'h3, 8'hA3, 8'hB3);
            end
            begin
                repeat (15) @(negedge clk);
                send_loc(8'hC1, 8'hD1);
                send_loc(8'hC2, 8'hD2);
                send_loc(8'hC3, 8'hD3);
            end
            begin
                repeat (30) @(negedge clk);
                dn_ready = 1;
            end
        join
        wait_drain("R5");
        chk(src_log.size() == start + 6, "R5", "six records logged", src_log.size() - start, 6);
        for (int i = 0; i < 6 && start + i < src_log.size(); i++)
            chk(src_log[start + i] == ((i % 2) == 0), "R5", "source order F,L,F,L,F,L",
                src_log[start + i], (i % 2) == 0);

        // R6: fill level stops the upstream port
        dn_ready = 0;
        up_accepted = 0;
        fork
            begin
                for (int i = 0; i < 6; i++)
                    send_up(4'h9, 8'(8'h40 + i), 8'(8'h80 + i));
            end
            begin
                repeat (40) @(negedge clk); #0.5;
                chk(up_accepted == LIMIT, "R6", "bytes taken before backpressure", up_accepted, LIMIT);
                chk(!up_ready, "R6", "up_ready low near full", up_ready, 0);
                dn_ready = 1;
            end
        join
        wait_drain("R6");

        // Random mix on the downstream port (R2, R3, R4, R9)
        rand_rdy = 1;
        fork
            begin
                for (int i = 0; i < 30; i++) begin
                    repeat ($urandom % 4) @(negedge clk);
                    send_up(other_addr(4'($urandom)), 8'($urandom), 8'($urandom));
                end
            end
            begin
                for (int i = 0; i < 30; i++) begin
                    repeat ($urandom % 4) @(negedge clk);
                    send_loc(8'($urandom), 8'($urandom));
                end
            end
        join
        wait_drain("R4");
        chk(!wrong_port, "R8", "host port quiet in chained mode", wrong_port, 0);

        // R8: top board sends to the host link
        rand_rdy = 0;
        do_reset(1, 0);
        wrong_port = 0;
        rand_rdy = 1;
        fork
            begin
                for (int i = 0; i < 10; i++)
                    send_up(other_addr(4'($urandom)), 8'($urandom), 8'($urandom));
            end
            begin
                for (int i = 0; i < 10; i++) send_loc(8'($urandom), 8'($urandom));
            end
        join
        wait_drain("R8");
        chk(!wrong_port, "R8", "downstream port quiet on top board", wrong_port, 0);

        // R7: bottom board ignores the upstream port
        rand_rdy = 0;
        do_reset(0, 1);
        dn_ready = 1;
        start = src_log.size();
        fork
            begin
                bit seen_ready;
                seen_ready = 0;
                @(negedge clk);
                up_valid = 1; up_byte = 8'h0A;
                for (int i = 0; i < 25; i++) begin
                    @(negedge clk); #0.5;
                    if (up_ready) seen_ready = 1;
                end
                up_valid = 0;
                chk(!seen_ready, "R7", "up_ready held low on bottom board", seen_ready, 0);
            end
            begin
                for (int i = 0; i < 4; i++) send_loc(8'(8'h60 + i), 8'(8'h70 + i));
            end
        join
        wait_drain("R7");
        nfwd = 0;
        for (int i = start; i < src_log.size(); i++) if (src_log[i]) nfwd++;
        chk(nfwd == 0, "R7", "no forwarded record from bottom board", nfwd, 0);
        chk(src_log.size() - start == 4, "R7", "local records still flow", src_log.size() - start, 4);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule